// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the address-latch strobe and the active-low program-read strobe of an 8-bit controller whose low address byte and data share one set of external pins. It also emits two selects. One tells the high address pins which source drives them. The other tells the shared low-byte pins whether they carry an address or data. A free-running phase counter divides each machine cycle into six states of two oscillator clocks each, so one machine cycle is twelve clocks. The strobe pattern of each cycle follows from a small set of per-cycle attributes.

The sequencer supplies those attributes: whether the cycle is an external data access, whether a code-table read is in progress, whether the data address is 16 or 8 bits wide, whether code runs from external program memory, and the software bit that silences the latch strobe. The block samples all five only on the clock edge that begins a machine cycle. They then govern the whole cycle. Every output comes straight from a flip-flop.

In a data-access cycle the first latch pulse is dropped and both program-read pulses are withheld. The cycle after it goes back to the normal pattern. The silencing bit is overridden whenever code runs externally, and also during data moves and code-table reads.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the outputs settle to `ale_o`=0, `psen_n_o`=1, `hi_sel_o`=0 and `lo_addr_o`=0, whatever the other inputs are.
- R2: When the latch strobe is enabled, `ale_o` is high for exactly the two clocks of state 0 and of state 3 in each 12-clock machine cycle. It is low in all other clocks, so it pulses once every 6 clocks.
- R3: In a cycle flagged as an external data access (`xdata_i`=1), the state-0 pulse of `ale_o` is dropped and the state-3 pulse is kept.
- R4: With `ale_off_i`=1, `ale_o` stays low for the whole cycle unless at least one of `ext_exec_i`, `xdata_i` or `tblrd_i` is 1 for that cycle. If any of them is 1, the pattern of R2/R3 applies.
- R5: When `ext_exec_i`=1 and the cycle is not a data access, `psen_n_o` is low in states 1, 2, 4 and 5, which is two active windows per cycle, each just after an `ale_o` fall. It is high in states 0 and 3. With `ext_exec_i`=0, `psen_n_o` stays high.
- R6: In a data-access cycle, `psen_n_o` stays high for all 12 clocks.
- R7: `hi_sel_o` is 0 (program counter) in non-data cycles. It is 1 (data pointer high byte) in data cycles with `xdata_wide_i`=1, and 2 (high port register) in data cycles with `xdata_wide_i`=0. The value holds for the whole cycle.
- R8: `lo_addr_o` is 1 (low pins carry an address) in states 0 and 3 and 0 (data) in all other states, whatever the cycle type.
- R9: The cycle inputs are sampled only on the edge that starts a machine cycle. A change in the middle of a cycle leaves that cycle's outputs unchanged.
- R10: The cycle that follows a data-access cycle shows the full non-data pattern for its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| xdata_i | input | 1 | Coming cycle is an external data access |
| tblrd_i | input | 1 | Code-table read in progress |
| xdata_wide_i | input | 1 | Data access uses a 16-bit address |
| ext_exec_i | input | 1 | Code executes from external program memory |
| ale_off_i | input | 1 | Software bit silencing the latch strobe |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program memory read strobe, active low |
| hi_sel_o | output | 2 | High address source: 0 program counter, 1 data pointer, 2 port register |
| lo_addr_o | output | 1 | Low-byte pins carry address (1) or data (0) |

## Verification
The bench builds the block with its defaults: six states of two clocks, with latch pulses in states 0 and 3. A machine cycle is then twelve clocks, so every phase slot can be compared against a pattern computed arithmetically. The bench sweeps all 32 combinations of the five cycle inputs, one machine cycle each, checking every output on every clock. Because the sweep advances in binary order, data-access cycles are followed by non-data cycles. Further cycles flip all inputs in mid-cycle to show that only the cycle-start sample counts.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  typedef enum logic [1:0] {
    HI_PC   = 2'd0,
    HI_DPTR = 2'd1,
    HI_PORT = 2'd2
  } hi_src_e;

  typedef struct packed {
    logic xdata;
    logic tblrd;
    logic wide;
    logic ext;
    logic ale_off;
  } cyc_attr_t;

endpackage

// File: rtl/xbs_phase.sv
module xbs_phase #(
  parameter int STATES = 6,
  parameter int CPS    = 2,
  localparam int SW    = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int SUBW  = (CPS > 1) ? $clog2(CPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] st_q,
  output logic [SW-1:0] st_d,
  output logic          wrap
);

  logic [SUBW-1:0] sub_q, sub_d;
  logic            sub_last, st_last;

  assign sub_last = (sub_q == SUBW'(CPS - 1));
  assign st_last  = (st_q == SW'(STATES - 1));
  assign wrap     = sub_last && st_last;

  always_comb begin
    sub_d = sub_last ? '0 : sub_q + SUBW'(1);
    st_d  = st_q;
    if (sub_last) st_d = st_last ? '0 : st_q + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= SUBW'(CPS - 1);
      st_q  <= SW'(STATES - 1);
    end else begin
      sub_q <= sub_d;
      st_q  <= st_d;
    end
  end

endmodule

// File: rtl/xbs_attr.sv
module xbs_attr
  import xbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wrap,
  input  cyc_attr_t attr_i,
  output cyc_attr_t attr_q,
  output cyc_attr_t attr_d
);

  assign attr_d = wrap ? attr_i : attr_q;

  always_ff @(posedge clk) begin
    if (rst) attr_q <= '0;
    else     attr_q <= attr_d;
  end

endmodule

// File: rtl/xbs_decode.sv
module xbs_decode
  import xbs_pkg::*;
#(
  parameter int STATES = 6,
  parameter int ALE_A  = 0,
  parameter int ALE_B  = 3,
  localparam int SW    = (STATES > 1) ? $clog2(STATES) : 1
) (
  input  logic [SW-1:0] st,
  input  cyc_attr_t     attr,
  output logic          ale,
  output logic          psen_n,
  output hi_src_e       hi_sel,
  output logic          lo_addr
);

  logic [STATES-1:0] addr_slot;
  logic [STATES-1:0] skip_slot;

  for (genvar s = 0; s < STATES; s++) begin : g_slot
    assign addr_slot[s] = (s == ALE_A) || (s == ALE_B);
    assign skip_slot[s] = (s == ALE_A);
  end

  logic slot, skip, ale_en;

  assign slot   = addr_slot[st];
  assign skip   = attr.xdata && skip_slot[st];
  assign ale_en = !attr.ale_off || attr.ext || attr.xdata || attr.tblrd;

  always_comb begin
    ale     = slot && ale_en && !skip;
    psen_n  = !(attr.ext && !attr.xdata && !slot);
    lo_addr = slot;
    if (!attr.xdata)    hi_sel = HI_PC;
    else if (attr.wide) hi_sel = HI_DPTR;
    else                hi_sel = HI_PORT;
  end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbs_pkg::*;
#(
  parameter int STATES      = 6,
  parameter int CPS         = 2,
  parameter int ALE_STATE_A = 0,
  parameter int ALE_STATE_B = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xdata_i,
  input  logic       tblrd_i,
  input  logic       xdata_wide_i,
  input  logic       ext_exec_i,
  input  logic       ale_off_i,
  output logic       ale_o,
  output logic       psen_n_o,
  output logic [1:0] hi_sel_o,
  output logic       lo_addr_o
);

  localparam int SW = (STATES > 1) ? $clog2(STATES) : 1;

  logic [SW-1:0] st_q, st_d;
  logic          wrap;
  cyc_attr_t     attr_in, attr_q, attr_d;

  assign attr_in = '{xdata: xdata_i, tblrd: tblrd_i, wide: xdata_wide_i,
                     ext: ext_exec_i, ale_off: ale_off_i};

  xbs_phase #(.STATES(STATES), .CPS(CPS)) u_phase (
    .clk(clk), .rst(rst), .st_q(st_q), .st_d(st_d), .wrap(wrap)
  );

  xbs_attr u_attr (
    .clk(clk), .rst(rst), .wrap(wrap),
    .attr_i(attr_in), .attr_q(attr_q), .attr_d(attr_d)
  );

  logic    ale_n, psen_n_n, lo_n;
  hi_src_e hi_n;

  xbs_decode #(.STATES(STATES), .ALE_A(ALE_STATE_A), .ALE_B(ALE_STATE_B)) u_dec (
    .st(st_d), .attr(attr_d),
    .ale(ale_n), .psen_n(psen_n_n), .hi_sel(hi_n), .lo_addr(lo_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o     <= 1'b0;
      psen_n_o  <= 1'b1;
      hi_sel_o  <= HI_PC;
      lo_addr_o <= 1'b0;
    end else begin
      ale_o     <= ale_n;
      psen_n_o  <= psen_n_n;
      hi_sel_o  <= hi_n;
      lo_addr_o <= lo_n;
    end
  end

endmodule

// File: rtl/xbus_strobe_gen_chk.sv
module xbus_strobe_gen_chk
  import xbs_pkg::*;
#(
  parameter int STATES = 6,
  parameter int CPS    = 2,
  parameter int ALE_A  = 0,
  localparam int SW    = (STATES > 1) ? $clog2(STATES) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ale_o,
  input logic          psen_n_o,
  input logic [1:0]    hi_sel_o,
  input logic          lo_addr_o,
  input logic [SW-1:0] st_q,
  input cyc_attr_t     attr_q
);

  // R2, R8: the latch strobe only appears in an address slot
  assert_ale_in_addr_slot_R2: assert property (@(posedge clk) disable iff (rst)
    ale_o |-> lo_addr_o);

  if (CPS > 1) begin : g_width
    // R2: a pulse lasts longer than one clock
    assert_ale_width_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(ale_o) |=> ale_o);
  end

  // R3: the first pulse of a data-access cycle is dropped
  assert_ale_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (attr_q.xdata && st_q == SW'(ALE_A)) |-> !ale_o);

  // R4: a silenced strobe needs an override
  assert_ale_off_R4: assert property (@(posedge clk) disable iff (rst)
    (attr_q.ale_off && !attr_q.ext && !attr_q.xdata && !attr_q.tblrd) |-> !ale_o);

  // R5: the program strobe needs external execution and never overlaps the latch strobe
  assert_psen_ext_R5: assert property (@(posedge clk) disable iff (rst)
    !psen_n_o |-> (attr_q.ext && !ale_o));

  // R6: no program strobe in a data cycle
  assert_psen_xdata_R6: assert property (@(posedge clk) disable iff (rst)
    attr_q.xdata |-> psen_n_o);

  // R7: data pointer only in wide data cycles
  assert_hi_dptr_R7: assert property (@(posedge clk) disable iff (rst)
    (hi_sel_o == 2'd1) |-> (attr_q.xdata && attr_q.wide));

  // R9: attributes are frozen within a cycle
  assert_attr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q != '0) |=> (st_q == '0) || $stable(attr_q));

endmodule

bind xbus_strobe_gen xbus_strobe_gen_chk #(
  .STATES(STATES), .CPS(CPS), .ALE_A(ALE_STATE_A)
) u_chk (
  .clk(clk), .rst(rst), .ale_o(ale_o), .psen_n_o(psen_n_o),
  .hi_sel_o(hi_sel_o), .lo_addr_o(lo_addr_o), .st_q(st_q), .attr_q(attr_q)
);

// File: tb/xbus_strobe_gen_tb.sv
module xbus_strobe_gen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xdata_i = 0, tblrd_i = 0, xdata_wide_i = 0, ext_exec_i = 0, ale_off_i = 0;
  logic ale_o, psen_n_o, lo_addr_o;
  logic [1:0] hi_sel_o;

  int n_run  = 0;
  int n_fail = 0;
  bit prev_x = 0;

  always #5 clk = ~clk;

  xbus_strobe_gen u_dut (
    .clk(clk), .rst(rst), .xdata_i(xdata_i), .tblrd_i(tblrd_i),
    .xdata_wide_i(xdata_wide_i), .ext_exec_i(ext_exec_i), .ale_off_i(ale_off_i),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .hi_sel_o(hi_sel_o), .lo_addr_o(lo_addr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cfg bits: [0] xdata, [1] table read, [2] wide, [3] ext exec, [4] ale off
  task automatic drive(input logic [4:0] c);
    xdata_i = c[0]; tblrd_i = c[1]; xdata_wide_i = c[2];
    ext_exec_i = c[3]; ale_off_i = c[4];
  endtask

  task automatic run_cycle(input logic [4:0] c, input bit glitch);
    drive(c);
    for (int j = 0; j < 12; j++) begin
      int  s;
      bit  slot, en, e_ale, e_psen;
      int  e_hi;
      string ra, rp;
      @(posedge clk);
      @(negedge clk);
      s      = j / 2;
      slot   = (s == 0) || (s == 3);
      en     = !c[4] || c[3] || c[0] || c[1];
      e_ale  = slot && en && !(c[0] && s == 0);
      e_psen = !(c[3] && !c[0] && !slot);
      e_hi   = c[0] ? (c[2] ? 1 : 2) : 0;
      ra = glitch ? "R9" : prev_x ? "R10" : (c[0] && s == 0) ? "R3" : c[4] ? "R4" : "R2";
      rp = glitch ? "R9" : prev_x ? "R10" : c[0] ? "R6" : "R5";
      check(ra, int'(ale_o), int'(e_ale));
      check(rp, int'(psen_n_o), int'(e_psen));
      check(glitch ? "R9" : "R7", int'(hi_sel_o), e_hi);
      check("R8", int'(lo_addr_o), int'(slot));
      if (glitch && j == 3)  drive(~c);
      if (glitch && j == 10) drive(c);
    end
    prev_x = c[0];
  endtask

  initial begin
    drive(5'b11111);
    repeat (3) @(negedge clk);
    // R1: reset values despite active inputs
    check("R1", int'(ale_o), 0);
    check("R1", int'(psen_n_o), 1);
    check("R1", int'(hi_sel_o), 0);
    check("R1", int'(lo_addr_o), 0);
    rst = 1'b0;
    for (int m = 0; m < 32; m++) run_cycle(5'(m), 1'b0);
    run_cycle(5'b01000, 1'b1);
    run_cycle(5'b00101, 1'b1);
    run_cycle(5'b11001, 1'b1);
    run_cycle(5'b00000, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule